// File: doc/BRIEF.md
# Packet Character Queue

This block buffers packet characters in both directions between an application and a serial link engine, all on one clock. A character is nine bits: an 8-bit code plus a marker flag. With the flag clear the code is an ordinary data byte. With the flag set, code 0x00 ends a packet normally and code 0x01 ends it with an error.

The application writes into the transmit queue with a write/ready handshake. The link engine drains that queue through a valid/take handshake. In the other direction the link engine pushes received characters into the receive queue. The application sees the oldest received character with a valid flag and removes it with a take strobe. Each queue reports when it is at least half full. A push into a full receive queue is discarded and signalled on an overflow output in the same cycle.

Both queues are 2^`DEPTH_LOG2` entries deep. Any power of two is allowed, including 2048 entries (`DEPTH_LOG2` = 11).

Top module: `pkt_char_queue`

## Requirements
- R1: A character enters the transmit queue at a rising edge only when `app_wr_en` and `app_wr_rdy` are both high. While `app_wr_rdy` is low, `app_wr_en` has no effect.
- R2: `app_wr_rdy` is high exactly when the transmit queue holds fewer than 2^`DEPTH_LOG2` characters.
- R3: `app_wr_half` is high exactly when the transmit queue holds at least 2^(`DEPTH_LOG2`-1) characters.
- R4: All nine bits of every character (bit 8 is the marker, bits 7:0 the code) come out unchanged and in arrival order. A marker with code 0x00 is a normal packet end and with code 0x01 an error packet end; these pass through like any other character.
- R5: `app_rd_vld` is high exactly when the receive queue is not empty. While it is high, `app_rd_mark` and `app_rd_byte` show the oldest received character.
- R6: When `app_rd_vld` and `app_rd_take` are both high at a rising edge, the head character is removed and the next one appears after that edge. `app_rd_take` does nothing while `app_rd_vld` is low.
- R7: `app_rd_half` is high exactly when the receive queue holds at least 2^(`DEPTH_LOG2`-1) characters.
- R8: A link push into a full receive queue is dropped. `lnk_rx_ovf` is high in the same cycle as that push, and only then.
- R9: When a push and a pop are both accepted on one queue at the same edge, its occupancy stays the same.
- R10: A synchronous reset empties both queues. After the reset edge, `app_wr_rdy` is high and `app_rd_vld`, `lnk_tx_vld` and both half flags are low.
- R11: `lnk_tx_vld` is high exactly when the transmit queue is not empty. It shows the oldest transmit character, which is removed when `lnk_tx_take` is high at an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_wr_en | input | 1 | Application write strobe |
| app_wr_mark | input | 1 | Marker flag of the written character |
| app_wr_byte | input | 8 | Code of the written character |
| app_wr_rdy | output | 1 | Transmit queue has room |
| app_wr_half | output | 1 | Transmit queue at least half full |
| app_rd_vld | output | 1 | Receive head is valid |
| app_rd_mark | output | 1 | Marker flag of the receive head |
| app_rd_byte | output | 8 | Code of the receive head |
| app_rd_take | input | 1 | Application removes the receive head |
| app_rd_half | output | 1 | Receive queue at least half full |
| lnk_tx_vld | output | 1 | Transmit head is valid |
| lnk_tx_mark | output | 1 | Marker flag of the transmit head |
| lnk_tx_byte | output | 8 | Code of the transmit head |
| lnk_tx_take | input | 1 | Link removes the transmit head |
| lnk_rx_push | input | 1 | Link pushes a received character |
| lnk_rx_mark | input | 1 | Marker flag of the pushed character |
| lnk_rx_byte | input | 8 | Code of the pushed character |
| lnk_rx_ovf | output | 1 | Current push is dropped because the queue is full |

## Verification
Every flag and head output is registered state. Each one reflects the handshakes of the previous rising edge, so the bench samples at the falling edge and compares against a model updated at that rising edge. `lnk_rx_ovf` is the only combinational result: it depends on the current push and the current occupancy. The bench therefore checks it one time step after driving the inputs, before the next edge. Directed phases overfill both queues and pop and push together at full. They also take from an empty queue and reset in mid-traffic. Seeded random traffic with shifting biases covers the rest.

// File: rtl/pcq_pkg.sv
package pcq_pkg;
    localparam int CHAR_W = 9;
    localparam logic [7:0] CODE_END_OK  = 8'h00;
    localparam logic [7:0] CODE_END_ERR = 8'h01;

    typedef struct packed {
        logic       mark;
        logic [7:0] code;
    } pcq_char_t;
endpackage

// File: rtl/pcq_level.sv
module pcq_level #(
    parameter int AW = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic empty,
    output logic half
);
    localparam logic [AW:0] DEPTH = (AW+1)'(1) << AW;
    localparam logic [AW:0] HALF  = (AW+1)'(1) << (AW - 1);

    logic [AW:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign full  = (cnt == DEPTH);
    assign empty = (cnt == '0);
    assign half  = (cnt >= HALF);
endmodule

// File: rtl/pcq_fifo.sv
module pcq_fifo
    import pcq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  pcq_char_t push_data,
    input  logic      pop,
    output logic      can_push,
    output logic      has_data,
    output logic      half,
    output pcq_char_t head
);
    localparam int DEPTH = 1 << AW;

    pcq_char_t     mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          full;
    logic          empty;
    logic          push_ok;
    logic          pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    pcq_level #(.AW(AW)) u_level (
        .clk   (clk),
        .rst   (rst),
        .inc   (push_ok),
        .dec   (pop_ok),
        .full  (full),
        .empty (empty),
        .half  (half)
    );

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
        end
    end

    assign can_push = !full;
    assign has_data = !empty;
    assign head     = mem[rp];
endmodule

// File: rtl/pkt_char_queue.sv
module pkt_char_queue
    import pcq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       app_wr_en,
    input  logic       app_wr_mark,
    input  logic [7:0] app_wr_byte,
    output logic       app_wr_rdy,
    output logic       app_wr_half,
    output logic       app_rd_vld,
    output logic       app_rd_mark,
    output logic [7:0] app_rd_byte,
    input  logic       app_rd_take,
    output logic       app_rd_half,
    output logic       lnk_tx_vld,
    output logic       lnk_tx_mark,
    output logic [7:0] lnk_tx_byte,
    input  logic       lnk_tx_take,
    input  logic       lnk_rx_push,
    input  logic       lnk_rx_mark,
    input  logic [7:0] lnk_rx_byte,
    output logic       lnk_rx_ovf
);
    pcq_char_t tx_in, tx_head, rx_in, rx_head;
    logic      rx_room;

    assign tx_in = '{mark: app_wr_mark, code: app_wr_byte};
    assign rx_in = '{mark: lnk_rx_mark, code: lnk_rx_byte};

    // application -> link direction
    pcq_fifo #(.AW(DEPTH_LOG2)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .push      (app_wr_en),
        .push_data (tx_in),
        .pop       (lnk_tx_take),
        .can_push  (app_wr_rdy),
        .has_data  (lnk_tx_vld),
        .half      (app_wr_half),
        .head      (tx_head)
    );

    // link -> application direction
    pcq_fifo #(.AW(DEPTH_LOG2)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .push      (lnk_rx_push),
        .push_data (rx_in),
        .pop       (app_rd_take),
        .can_push  (rx_room),
        .has_data  (app_rd_vld),
        .half      (app_rd_half),
        .head      (rx_head)
    );

    assign lnk_tx_mark = tx_head.mark;
    assign lnk_tx_byte = tx_head.code;
    assign app_rd_mark = rx_head.mark;
    assign app_rd_byte = rx_head.code;
    assign lnk_rx_ovf  = lnk_rx_push && !rx_room;
endmodule

// File: rtl/pkt_char_queue_chk.sv
module pkt_char_queue_chk (
    input logic       clk,
    input logic       rst,
    input logic       app_wr_en,
    input logic       app_wr_rdy,
    input logic       app_wr_half,
    input logic       app_rd_vld,
    input logic       app_rd_mark,
    input logic [7:0] app_rd_byte,
    input logic       app_rd_take,
    input logic       app_rd_half,
    input logic       lnk_tx_vld,
    input logic       lnk_tx_mark,
    input logic [7:0] lnk_tx_byte,
    input logic       lnk_tx_take,
    input logic       lnk_rx_push,
    input logic       lnk_rx_ovf
);
    // R1
    wr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (app_wr_en && !app_wr_rdy && !lnk_tx_take) |=> !app_wr_rdy);

    // R3
    full_implies_half_chk: assert property (@(posedge clk) disable iff (rst)
        !app_wr_rdy |-> (app_wr_half && lnk_tx_vld));

    // R6
    empty_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!app_rd_vld && !lnk_rx_push) |=> !app_rd_vld);

    // R5
    rd_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (app_rd_vld && !app_rd_take) |=>
            (app_rd_vld && $stable(app_rd_mark) && $stable(app_rd_byte)));

    // R11
    tx_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lnk_tx_vld && !lnk_tx_take) |=>
            (lnk_tx_vld && $stable(lnk_tx_mark) && $stable(lnk_tx_byte)));

    // R7
    rd_half_chk: assert property (@(posedge clk) disable iff (rst)
        app_rd_half |-> app_rd_vld);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        lnk_rx_ovf |-> (lnk_rx_push && app_rd_half && app_rd_vld));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (app_wr_rdy && !app_wr_half && !app_rd_vld && !lnk_tx_vld && !app_rd_half));
endmodule

bind pkt_char_queue pkt_char_queue_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .app_wr_en   (app_wr_en),
    .app_wr_rdy  (app_wr_rdy),
    .app_wr_half (app_wr_half),
    .app_rd_vld  (app_rd_vld),
    .app_rd_mark (app_rd_mark),
    .app_rd_byte (app_rd_byte),
    .app_rd_take (app_rd_take),
    .app_rd_half (app_rd_half),
    .lnk_tx_vld  (lnk_tx_vld),
    .lnk_tx_mark (lnk_tx_mark),
    .lnk_tx_byte (lnk_tx_byte),
    .lnk_tx_take (lnk_tx_take),
    .lnk_rx_push (lnk_rx_push),
    .lnk_rx_ovf  (lnk_rx_ovf)
);

// File: tb/pkt_char_queue_tb.sv
module pkt_char_queue_tb;
    import pcq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int D          = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       app_wr_en = 1'b0, app_wr_mark = 1'b0;
    logic [7:0] app_wr_byte = '0;
    logic       app_wr_rdy, app_wr_half, app_rd_vld, app_rd_mark, app_rd_half;
    logic [7:0] app_rd_byte;
    logic       app_rd_take = 1'b0;
    logic       lnk_tx_vld, lnk_tx_mark;
    logic [7:0] lnk_tx_byte;
    logic       lnk_tx_take = 1'b0, lnk_rx_push = 1'b0, lnk_rx_mark = 1'b0;
    logic [7:0] lnk_rx_byte = '0;
    logic       lnk_rx_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit after_rst = 0;
    logic [8:0] txq[$];
    logic [8:0] rxq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_char_queue #(.DEPTH_LOG2(AW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] gen_char(input int mark_pct);
        if (int'($urandom % 100) < mark_pct)
            return {1'b1, ($urandom % 2) ? CODE_END_ERR : CODE_END_OK};
        return {1'b0, 8'($urandom)};
    endfunction

    task automatic check_outputs();
        int ts = txq.size();
        int rs = rxq.size();
        chk(app_wr_rdy == (ts < D), "R2 R9 wr_rdy", int'(app_wr_rdy), int'(ts < D));
        chk(app_wr_half == (ts >= D/2), "R3 wr_half", int'(app_wr_half), int'(ts >= D/2));
        chk(lnk_tx_vld == (ts > 0), "R11 tx_vld", int'(lnk_tx_vld), int'(ts > 0));
        if (ts > 0)
            chk({lnk_tx_mark, lnk_tx_byte} == txq[0], "R1 R4 R11 tx_head",
                int'({lnk_tx_mark, lnk_tx_byte}), int'(txq[0]));
        chk(app_rd_vld == (rs > 0), "R5 R6 rd_vld", int'(app_rd_vld), int'(rs > 0));
        if (rs > 0)
            chk({app_rd_mark, app_rd_byte} == rxq[0], "R4 R5 R6 R9 rd_head",
                int'({app_rd_mark, app_rd_byte}), int'(rxq[0]));
        chk(app_rd_half == (rs >= D/2), "R7 rd_half", int'(app_rd_half), int'(rs >= D/2));
        if (after_rst)
            chk(app_wr_rdy && !app_rd_vld && !lnk_tx_vld && !app_wr_half && !app_rd_half,
                "R10 reset state", int'({app_wr_rdy, app_rd_vld, lnk_tx_vld}), 4);
    endtask

    task automatic step(input logic r, input logic we, input logic [8:0] wc,
                        input logic tk, input logic ltk, input logic lp,
                        input logic [8:0] lc);
        int ts, rs;
        @(negedge clk);
        check_outputs();
        rst = r;
        app_wr_en = we;
        {app_wr_mark, app_wr_byte} = wc;
        app_rd_take = tk;
        lnk_tx_take = ltk;
        lnk_rx_push = lp;
        {lnk_rx_mark, lnk_rx_byte} = lc;
        #1;
        if (!r)
            chk(lnk_rx_ovf == (lp && rxq.size() == D), "R8 ovf",
                int'(lnk_rx_ovf), int'(lp && rxq.size() == D));
        @(posedge clk);
        ts = txq.size();
        rs = rxq.size();
        after_rst = r;
        if (r) begin
            txq.delete();
            rxq.delete();
        end else begin
            if (ltk && ts > 0) void'(txq.pop_front());
            if (we && ts < D) txq.push_back(wc);       // R1: ignored when full
            if (tk && rs > 0) void'(rxq.pop_front());  // R6: ignored when empty
            if (lp && rs < D) rxq.push_back(lc);       // R8: dropped when full
        end
    endtask

    task automatic run_random(input int n, input int wp, input int tp, input int lp, input int kp);
        for (int i = 0; i < n; i++)
            step(1'b0, int'($urandom % 100) < wp, gen_char(25), int'($urandom % 100) < kp,
                 int'($urandom % 100) < tp, int'($urandom % 100) < lp, gen_char(25));
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R10 reset
        for (int i = 0; i < 3; i++) step(1'b1, 0, '0, 0, 0, 0, '0);
        // R1 R2 R3: overfill transmit side, markers included
        for (int i = 0; i < D + 4; i++) step(1'b0, 1, gen_char(40), 0, 0, 0, '0);
        // R8 R7: overfill receive side
        for (int i = 0; i < D + 4; i++) step(1'b0, 0, '0, 0, 0, 1, gen_char(40));
        // R9: push and pop together while full
        for (int i = 0; i < 8; i++) step(1'b0, 1, gen_char(40), 1, 1, 1, gen_char(40));
        // R4 explicit markers through both sides
        step(1'b0, 0, '0, 1, 1, 1, {1'b1, CODE_END_OK});
        step(1'b0, 0, '0, 1, 1, 1, {1'b1, CODE_END_ERR});
        // drain both
        for (int i = 0; i < D + 4; i++) step(1'b0, 0, '0, 1, 1, 0, '0);
        // R6: take while empty
        for (int i = 0; i < 4; i++) step(1'b0, 0, '0, 1, 1, 0, '0);
        run_random(1500, 70, 30, 70, 30);
        run_random(1500, 30, 70, 30, 70);
        run_random(800, 50, 50, 50, 50);
        // R10: reset in mid traffic
        step(1'b1, 1, gen_char(0), 1, 1, 1, gen_char(0));
        run_random(500, 60, 40, 60, 40);
        step(1'b0, 0, '0, 0, 0, 0, '0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule